// File: doc/BRIEF.md
# Load-Reserve Store-Conditional Monitor

This block keeps the single atomic-access reservation of one processor core that shares memory with other bus masters over two buses: a fast local bus (bus 0) and a slower peripheral bus (bus 1). When the core issues a load-reserve, the monitor stores the word address and raises a valid flag. The monitor watches every write on both buses. A write from any other master that overlaps the reserved word drops the flag. One clock later the monitor pulses a cancel line so that the core can discard its own copy of the reservation.

When the core issues a store-conditional, the monitor decides in the same cycle whether the write may go out on the bus. It allows the write only if the flag is set, the address matches the reserved word, and no foreign write hits that word in the same cycle. One clock later it returns a success bit to the core. Bus arbitration, the memories and the core's condition-register update are outside this block. Requests and snoops arrive as single-cycle strobes that carry an address, a size code and a master ID.

Top module: `resv_monitor`

## Requirements
- R1: Synchronous active-high reset clears the reservation flag, the cancel output and the status-valid output.
- R2: A core load-reserve (`core_lr_i`) sets the flag and stores `core_word_i` in place of any earlier reservation. It does so even when `core_aphase_err_i` is 1 in that cycle.
- R3: A core store-conditional (`core_sc_i`) raises `sc_launch_o` in the same cycle when the flag is set and `core_word_i` equals the reserved word. In the next cycle `sc_status_valid_o` is 1, and `sc_status_ok_o` is 1 only if the write was launched and `core_aphase_err_i` was 0.
- R4: A launched store-conditional whose address phase ends normally (`core_aphase_err_i` = 0) clears the flag. A launched store-conditional that ends in an address-phase error leaves the flag set.
- R5: A store-conditional issued while the flag is clear, or to a word other than the reserved one, is not launched and reports failure. It also clears the flag.
- R6: A write (`snp_write_i` = 1) from a master whose ID differs from `CORE_ID` clears the flag when it overlaps the reserved word. The size code is 0 for a byte, 1 for a half-word, 2 for a word and 3 for an 8-byte doubleword. Byte, half-word and word writes overlap when byte-address bits [ADDR_W-1:2] match the reserved word. A doubleword write overlaps when bits [ADDR_W-1:3] match.
- R7: The flag is not affected by reads, by writes carrying the `CORE_ID` master ID, or by foreign writes that do not overlap the reserved word.
- R8: Writes are snooped on the local bus (index 0) and on the peripheral bus (index 1) alike.
- R9: When the flag is lost to a foreign write, `cancel_o` is 1 for exactly the one following cycle. A store-conditional issued in that cycle is not launched.
- R10: When a foreign write hitting the old reservation and a core load-reserve arrive in the same cycle, the new reservation is kept and no cancel is raised.
- R11: When a foreign write hitting the reserved word and a core store-conditional to that word arrive in the same cycle, the store-conditional is not launched and reports failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_lr_i | input | 1 | Core load-reserve request strobe |
| core_sc_i | input | 1 | Core store-conditional request strobe |
| core_word_i | input | ADDR_W-2 | Word address of the core request |
| core_aphase_err_i | input | 1 | Address phase of the core request ended in error |
| snp_valid_i | input | NUM_BUS | Per-bus snooped transfer strobe |
| snp_write_i | input | NUM_BUS | Per-bus transfer is a write |
| snp_id_i | input | NUM_BUS*ID_W | Per-bus master ID |
| snp_addr_i | input | NUM_BUS*ADDR_W | Per-bus byte address |
| snp_size_i | input | NUM_BUS*2 | Per-bus size code |
| sc_launch_o | output | 1 | Store-conditional may drive its write onto the bus |
| sc_status_valid_o | output | 1 | Store-conditional result is present (one cycle after the request) |
| sc_status_ok_o | output | 1 | Store-conditional succeeded |
| cancel_o | output | 1 | Reservation lost to a foreign write in the previous cycle |
| resv_valid_o | output | 1 | Current reservation flag |

## Verification
The bench targets same-cycle collisions. A design that gives snoop clears priority over a new load-reserve loses a fresh reservation and raises a false cancel. A design that compares against the flag registered one cycle earlier launches a store-conditional that collides with a foreign write. The bench also covers sizes and overlap. A design that ignores the doubleword size misses a write to the neighbouring word of an 8-byte pair. A design that ignores the master ID lets the core's own stores break its reservation. The remaining checks cover the address-phase error cases: a load-reserve that ends in error must still set the flag, and a launched store-conditional that ends in error must keep it. They also cover cancel timing, where a pulse that is late or two cycles wide shows up directly at the cancel output.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } snp_size_e;
endpackage

// File: rtl/resv_snoop.sv
module resv_snoop
   import resv_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ID_W    = 3,
   parameter int CORE_ID = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ID_W-1:0]   id_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   input  logic [ADDR_W-3:0] resv_word_i,
   output logic              hit_o
);
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [ID_W-1:0] OWN_ID = ID_W'(CORE_ID);

   logic foreign;
   logic word_match;
   logic dword_match;
   snp_size_e size_e;

   assign size_e      = snp_size_e'(size_i);
   assign foreign     = (id_i != OWN_ID);
   assign word_match  = (addr_i[ADDR_W-1:2] == resv_word_i);
   assign dword_match = (addr_i[ADDR_W-1:3] == resv_word_i[WORD_W-1:1]);

   always_comb begin
      hit_o = 1'b0;
      if (valid_i && write_i && foreign) begin
         if (size_e == SZ_DWORD) hit_o = dword_match;
         else                    hit_o = word_match;
      end
   end

   // R6: snooped writes are naturally aligned for their size
   a_r6_half_aligned: assert property (@(posedge clk) disable iff (rst)
      (valid_i && write_i && size_e == SZ_HALF) |-> (addr_i[0] == 1'b0));
   a_r6_word_aligned: assert property (@(posedge clk) disable iff (rst)
      (valid_i && write_i && size_e == SZ_WORD) |-> (addr_i[1:0] == 2'b00));
   a_r6_dword_aligned: assert property (@(posedge clk) disable iff (rst)
      (valid_i && write_i && size_e == SZ_DWORD) |-> (addr_i[2:0] == 3'b000));
endmodule

// File: rtl/resv_entry.sv
module resv_entry #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_i,
   input  logic [WORD_W-1:0] set_word_i,
   input  logic              clr_i,
   output logic              flag_o,
   output logic [WORD_W-1:0] word_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         flag_o <= 1'b0;
         word_o <= '0;
      end else if (set_i) begin
         flag_o <= 1'b1;
         word_o <= set_word_i;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> !flag_o);
   a_r2_set_loads: assert property (@(posedge clk) disable iff (rst)
      set_i |=> (flag_o && word_o == $past(set_word_i)));
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/resv_sc_gate.sv
module resv_sc_gate #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sc_req_i,
   input  logic [WORD_W-1:0] sc_word_i,
   input  logic              aphase_err_i,
   input  logic              flag_i,
   input  logic [WORD_W-1:0] resv_word_i,
   input  logic              lost_now_i,
   output logic              launch_o,
   output logic              clr_o,
   output logic              stat_valid_o,
   output logic              stat_ok_o
);
   logic addr_ok;

   assign addr_ok  = (sc_word_i == resv_word_i);
   assign launch_o = sc_req_i && flag_i && addr_ok && !lost_now_i;
   assign clr_o    = sc_req_i && (!launch_o || !aphase_err_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_valid_o <= 1'b0;
         stat_ok_o    <= 1'b0;
      end else begin
         stat_valid_o <= sc_req_i;
         stat_ok_o    <= launch_o && !aphase_err_i;
      end
   end

   a_r5_no_launch_when_clear: assert property (@(posedge clk) disable iff (rst)
      !flag_i |-> !launch_o);
   a_r11_collision_blocks: assert property (@(posedge clk) disable iff (rst)
      lost_now_i |-> !launch_o);
   a_r3_status_next: assert property (@(posedge clk) disable iff (rst)
      sc_req_i |=> stat_valid_o);
   a_r3_ok_needs_launch: assert property (@(posedge clk) disable iff (rst)
      stat_ok_o |-> $past(launch_o));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ID_W    = 3,
   parameter int NUM_BUS = 2,
   parameter int CORE_ID = 0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      core_lr_i,
   input  logic                      core_sc_i,
   input  logic [ADDR_W-3:0]         core_word_i,
   input  logic                      core_aphase_err_i,
   input  logic [NUM_BUS-1:0]        snp_valid_i,
   input  logic [NUM_BUS-1:0]        snp_write_i,
   input  logic [NUM_BUS*ID_W-1:0]   snp_id_i,
   input  logic [NUM_BUS*ADDR_W-1:0] snp_addr_i,
   input  logic [NUM_BUS*2-1:0]      snp_size_i,
   output logic                      sc_launch_o,
   output logic                      sc_status_valid_o,
   output logic                      sc_status_ok_o,
   output logic                      cancel_o,
   output logic                      resv_valid_o
);
   localparam int WORD_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_chk_addr
      initial $fatal(1, "resv_monitor: ADDR_W must be at least 4");
   end
   if (ID_W < 1) begin : g_chk_id
      initial $fatal(1, "resv_monitor: ID_W must be at least 1");
   end
   if (NUM_BUS < 1) begin : g_chk_bus
      initial $fatal(1, "resv_monitor: NUM_BUS must be at least 1");
   end
   if (CORE_ID < 0 || CORE_ID >= (1 << ID_W)) begin : g_chk_core
      initial $fatal(1, "resv_monitor: CORE_ID does not fit in ID_W");
   end

   logic [NUM_BUS-1:0] bus_hit;
   logic               any_hit;
   logic               flag;
   logic [WORD_W-1:0]  resv_word;
   logic               sc_clr;
   logic               cancel_q;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      resv_snoop #(
         .ADDR_W (ADDR_W),
         .ID_W   (ID_W),
         .CORE_ID(CORE_ID)
      ) u_snoop (
         .clk        (clk),
         .rst        (rst),
         .valid_i    (snp_valid_i[b]),
         .write_i    (snp_write_i[b]),
         .id_i       (snp_id_i[b*ID_W +: ID_W]),
         .addr_i     (snp_addr_i[b*ADDR_W +: ADDR_W]),
         .size_i     (snp_size_i[b*2 +: 2]),
         .resv_word_i(resv_word),
         .hit_o      (bus_hit[b])
      );
   end

   assign any_hit = |bus_hit;

   resv_entry #(.WORD_W(WORD_W)) u_entry (
      .clk       (clk),
      .rst       (rst),
      .set_i     (core_lr_i),
      .set_word_i(core_word_i),
      .clr_i     (sc_clr || any_hit),
      .flag_o    (flag),
      .word_o    (resv_word)
   );

   resv_sc_gate #(.WORD_W(WORD_W)) u_gate (
      .clk         (clk),
      .rst         (rst),
      .sc_req_i    (core_sc_i),
      .sc_word_i   (core_word_i),
      .aphase_err_i(core_aphase_err_i),
      .flag_i      (flag),
      .resv_word_i (resv_word),
      .lost_now_i  (any_hit),
      .launch_o    (sc_launch_o),
      .clr_o       (sc_clr),
      .stat_valid_o(sc_status_valid_o),
      .stat_ok_o   (sc_status_ok_o)
   );

   always_ff @(posedge clk) begin
      if (rst) cancel_q <= 1'b0;
      else     cancel_q <= flag && any_hit && !core_lr_i;
   end

   assign cancel_o     = cancel_q;
   assign resv_valid_o = flag;

   a_r2_one_request: assert property (@(posedge clk) disable iff (rst)
      !(core_lr_i && core_sc_i));
   a_r9_cancel_follows_loss: assert property (@(posedge clk) disable iff (rst)
      (flag && any_hit && !core_lr_i) |=> (cancel_o && !resv_valid_o));
   a_r9_cancel_one_cycle: assert property (@(posedge clk) disable iff (rst)
      cancel_o |=> !cancel_o);
   a_r10_lr_wins: assert property (@(posedge clk) disable iff (rst)
      core_lr_i |=> (resv_valid_o && !cancel_o));
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!cancel_o && !sc_status_valid_o));
endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
   localparam int AW = 32;
   localparam int IW = 3;
   localparam int NB = 2;
   localparam int WW = AW - 2;

   logic clk = 1'b0;
   logic rst;
   logic core_lr, core_sc, core_err;
   logic [WW-1:0] core_word;
   logic [NB-1:0] s_valid, s_write;
   logic [NB*IW-1:0] s_id;
   logic [NB*AW-1:0] s_addr;
   logic [NB*2-1:0] s_size;
   logic launch, st_valid, st_ok, cancel, rvalid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   resv_monitor #(.ADDR_W(AW), .ID_W(IW), .NUM_BUS(NB), .CORE_ID(0)) u_resv_monitor (
      .clk(clk), .rst(rst),
      .core_lr_i(core_lr), .core_sc_i(core_sc), .core_word_i(core_word),
      .core_aphase_err_i(core_err),
      .snp_valid_i(s_valid), .snp_write_i(s_write), .snp_id_i(s_id),
      .snp_addr_i(s_addr), .snp_size_i(s_size),
      .sc_launch_o(launch), .sc_status_valid_o(st_valid), .sc_status_ok_o(st_ok),
      .cancel_o(cancel), .resv_valid_o(rvalid)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic idle();
      core_lr = 0; core_sc = 0; core_err = 0; core_word = '0;
      s_valid = '0; s_write = '0; s_id = '0; s_addr = '0; s_size = '0;
   endtask

   task automatic tick();
      @(negedge clk); idle(); #1;
   endtask

   task automatic put_snoop(input int bus, input int id, input logic [AW-1:0] a,
                            input int sz, input logic wr);
      s_valid[bus] = 1'b1;
      s_write[bus] = wr;
      s_id[bus*IW +: IW] = IW'(id);
      s_addr[bus*AW +: AW] = a;
      s_size[bus*2 +: 2] = 2'(sz);
   endtask

   task automatic lr(input logic [WW-1:0] w, input logic err);
      core_lr = 1; core_word = w; core_err = err;
      tick();
   endtask

   task automatic sc(input string req, input logic [WW-1:0] w, input logic err,
                     input logic exp_launch, input logic exp_ok);
      core_sc = 1; core_word = w; core_err = err; #1;
      chk({req, " launch"}, launch, exp_launch);
      tick();
      chk({req, " status_valid"}, st_valid, 1'b1);
      chk({req, " status_ok"}, st_ok, exp_ok);
   endtask

   // one snooped write, then check flag and cancel pulse
   task automatic snoop_one(input string req, input int bus, input int id,
                            input logic [AW-1:0] a, input int sz, input logic wr,
                            input logic exp_lost);
      put_snoop(bus, id, a, sz, wr);
      tick();
      chk({req, " flag"}, rvalid, !exp_lost);
      chk({req, " cancel"}, cancel, exp_lost);
      tick();
      chk({req, " cancel width"}, cancel, 1'b0);
   endtask

   task automatic t_reset();
      rst = 1; idle();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 flag", rvalid, 1'b0);
      chk("R1 cancel", cancel, 1'b0);
      chk("R1 status_valid", st_valid, 1'b0);
      @(negedge clk); rst = 0; #1;
   endtask

   task automatic t_basic();
      lr(30'h100, 0);
      chk("R2 set", rvalid, 1'b1);
      sc("R3 match", 30'h100, 0, 1, 1);
      chk("R4 cleared", rvalid, 1'b0);
      sc("R5 flag clear", 30'h100, 0, 0, 0);
   endtask

   task automatic t_replace();
      lr(30'h100, 0);
      lr(30'h200, 0);
      sc("R5 old word", 30'h100, 0, 0, 0);
      chk("R5 mismatch clears", rvalid, 1'b0);
      lr(30'h100, 0);
      lr(30'h200, 0);
      sc("R2 replaced word", 30'h200, 0, 1, 1);
   endtask

   task automatic t_errors();
      lr(30'h55, 1);
      chk("R2 set despite error", rvalid, 1'b1);
      sc("R4 aphase error", 30'h55, 1, 1, 0);
      chk("R4 error keeps flag", rvalid, 1'b1);
      sc("R4 retry", 30'h55, 0, 1, 1);
   endtask

   task automatic t_sizes();
      lr(30'h100, 0);
      snoop_one("R6 byte", 0, 3, 32'h403, 0, 1, 1);
      lr(30'h100, 0);
      snoop_one("R6 half", 0, 5, 32'h402, 1, 1, 1);
      lr(30'h100, 0);
      snoop_one("R6 word", 0, 1, 32'h400, 2, 1, 1);
      lr(30'h101, 0);
      snoop_one("R6 dword upper", 0, 2, 32'h400, 3, 1, 1);
   endtask

   task automatic t_nohit();
      lr(30'h100, 0);
      snoop_one("R7 neighbour word", 0, 2, 32'h404, 2, 1, 0);
      snoop_one("R7 read", 0, 2, 32'h400, 2, 0, 0);
      snoop_one("R7 own id", 0, 0, 32'h400, 2, 1, 0);
      snoop_one("R7 own id periph", 1, 0, 32'h400, 0, 1, 0);
      snoop_one("R7 other dword", 0, 2, 32'h408, 3, 1, 0);
      sc("R7 still reserved", 30'h100, 0, 1, 1);
   endtask

   task automatic t_periph();
      lr(30'h80, 0);
      snoop_one("R8 peripheral bus", 1, 4, 32'h201, 0, 1, 1);
      sc("R8 after loss", 30'h80, 0, 0, 0);
   endtask

   task automatic t_cancel_sc();
      lr(30'h90, 0);
      put_snoop(0, 6, 32'h240, 2, 1);
      tick();
      chk("R9 cancel", cancel, 1'b1);
      sc("R9 sc in cancel cycle", 30'h90, 0, 0, 0);
      chk("R9 cancel dropped", cancel, 1'b0);
   endtask

   task automatic t_same_lr();
      lr(30'h90, 0);
      put_snoop(0, 6, 32'h240, 2, 1);
      core_lr = 1; core_word = 30'h90;
      tick();
      chk("R10 same word kept", rvalid, 1'b1);
      chk("R10 no cancel", cancel, 1'b0);
      put_snoop(1, 6, 32'h240, 2, 1);
      core_lr = 1; core_word = 30'hA0;
      tick();
      chk("R10 new word flag", rvalid, 1'b1);
      chk("R10 new word no cancel", cancel, 1'b0);
      sc("R10 new word sc", 30'hA0, 0, 1, 1);
   endtask

   task automatic t_same_sc();
      lr(30'hB0, 0);
      put_snoop(0, 7, 32'h2C0, 1, 1);
      core_sc = 1; core_word = 30'hB0; #1;
      chk("R11 launch", launch, 1'b0);
      tick();
      chk("R11 status_ok", st_ok, 1'b0);
      chk("R11 status_valid", st_valid, 1'b1);
      chk("R11 flag", rvalid, 1'b0);
   endtask

   initial begin
      idle();
      t_reset();
      t_basic();
      t_replace();
      t_errors();
      t_sizes();
      t_nohit();
      t_periph();
      t_cancel_sc();
      t_same_lr();
      t_same_sc();
      tick();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule